// File: doc/BRIEF.md
# Three-Wire Serial NVRAM and Status Slave

This block sits on a three-line serial link that a host toggles from software. The lines are a select, a serial clock and a data bit. While select is high the host shifts a sixteen-bit frame into the slave, one bit per falling clock edge. The first eight bits form a command and the last eight form a value. The command picks one of four actions: read one byte of a 32-byte battery-style RAM, write one byte of that RAM, read a status byte, or write a control byte. A control write can clear a pending-event indication and the interrupt line that goes with it.

Read data comes back inside the same frame. Writes take effect only when the sixteenth bit has been taken in. If the host drops select early, the partial frame is discarded and nothing changes. The three host lines are asynchronous to the system clock, so each passes through a two-flop synchronizer before use. A test input raises the pending-event bits and the interrupt, which lets the clearing path be exercised.

Top module: `serial_nvram_slave`

## Requirements
- R1: After reset the status byte reads 0x90, every RAM byte reads 0x00, the interrupt output is low and the data output enable is low.
- R2: Bits are taken only on a falling edge of the synchronized serial clock, most significant bit first. A rising edge or a data change while the clock is high does not load a bit.
- R3: A command from 0x00 to 0x1F returns the RAM byte at that address in frame phases 8 to 15, bit 7 first. Phase p presents bit 15-p.
- R4: When a full frame with a command from 0x80 to 0x9F ends, the value byte is stored at RAM address command-0x80.
- R5: Command 0x30 returns the status byte serially in phases 8 to 15.
- R6: Command 0x31 and commands 0x20 to 0x2F return all-zero bits with the output enable asserted.
- R7: The output enable is high only during phases 8 to 15 of a read-type command (0x00 to 0x31). It is low during phases 0 to 7, at phase 16 and throughout any other command.
- R8: Dropping select clears the phase, command and value. A frame aborted before its sixteenth bit changes neither the RAM nor the status byte.
- R9: After the sixteenth bit, further falling edges are ignored until select drops, and the next frame starts at phase 0.
- R10: A one-cycle pulse on the event test input sets status bits 4 and 3 (mask 0x18) and raises the interrupt on the next clock.
- R11: A full frame with command 0xB1 and value bit 2 set clears status bits 4 and 3 and lowers the interrupt. With value bit 2 clear, it does neither.
- R12: Status bits outside mask 0x18 are not touched by the event input or the clear. After set-then-clear, the status byte reads 0x80 from its 0x90 reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel_i | input | 1 | Frame select from host, active high, asynchronous |
| host_sclk_i | input | 1 | Serial clock from host, asynchronous |
| host_sdata_i | input | 1 | Serial data from host, asynchronous |
| evt_force_i | input | 1 | Test pulse that sets the pending-event bits and the interrupt |
| slv_sdata_o | output | 1 | Serial data driven by the slave |
| slv_sdata_oe_o | output | 1 | Enable for slv_sdata_o; line released to host when low |
| evt_irq_o | output | 1 | Pending-event interrupt request |

## Verification
A host line change reaches the sequencer two clocks later through the synchronizer. The edge detector and phase register add one more clock, so phase, output data and enable settle three clocks after the host drops the clock. RAM and status commits land on that same clock. The bench holds each clock level for at least six system clocks and samples one nanosecond after a rising edge, well past that settling point. The event input is synchronous and shows on the interrupt one clock after the pulse. The bench waits two clocks before comparing.

// File: rtl/nvr_pkg.sv
// Package: shared constants and widths for the serial NVRAM slave.
package nvr_pkg;
    localparam int          BYTE_W     = 8;
    localparam int          PHASE_W    = 5;
    localparam int          FRAME_BITS = 16;
    localparam int          CMD_BITS   = 8;
    localparam logic [7:0]  STAT_RESET = 8'h90;
    localparam logic [7:0]  EVT_MASK   = 8'h18;
    localparam logic [7:0]  CMD_STAT   = 8'h30;
    localparam logic [7:0]  CMD_ZERO2  = 8'h31;
    localparam logic [7:0]  ZERO_LO    = 8'h20;
    localparam logic [7:0]  ZERO_HI    = 8'h2F;
    localparam logic [7:0]  RAM_WR_BASE = 8'h80;
    localparam logic [7:0]  CMD_CTL    = 8'hB1;
    localparam int          CLR_BIT    = 2;
endpackage

// File: rtl/nvr_sync.sv
// Module: nvr_sync
// Multi-stage synchronizer for a bundle of asynchronous single-bit lines.
// Assumes each line is quasi-static relative to clk (host bit-banging).
module nvr_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/nvr_seq.sv
// Module: nvr_seq
// Frame sequencer: detects falling serial-clock edges, counts phases 0..16,
// shifts command then value MSB first, and flags frame completion.
// Assumes sel, sclk and sdi are already synchronous to clk.
module nvr_seq
    import nvr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_i,
    input  logic               sclk_i,
    input  logic               sdi_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic [BYTE_W-1:0]  cmd_o,
    output logic               window_o,
    output logic [2:0]         bit_idx_o,
    output logic               commit_o,
    output logic [BYTE_W-1:0]  commit_val_o
);
    localparam logic [PHASE_W-1:0] PH_LAST = PHASE_W'(FRAME_BITS - 1);
    localparam logic [PHASE_W-1:0] PH_DONE = PHASE_W'(FRAME_BITS);
    localparam logic [PHASE_W-1:0] PH_DATA = PHASE_W'(CMD_BITS);

    logic               sclk_prev;
    logic               fall;
    logic [PHASE_W-1:0] phase;
    logic [BYTE_W-1:0]  cmd;
    logic [BYTE_W-1:0]  val;

    assign fall = sclk_prev & ~sclk_i;

    // Remember the previous clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_i;
    end

    // Advance the phase and shift bits on falling edges; clear when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_i) begin
            phase <= '0;
            cmd   <= '0;
            val   <= '0;
        end else if (fall && phase != PH_DONE) begin
            if (phase < PH_DATA) cmd <= {cmd[BYTE_W-2:0], sdi_i};
            else                 val <= {val[BYTE_W-2:0], sdi_i};
            phase <= phase + 1'b1;
        end
    end

    assign phase_o      = phase;
    assign cmd_o        = cmd;
    assign window_o     = sel_i && (phase >= PH_DATA) && (phase <= PH_LAST);
    assign bit_idx_o    = 3'd7 - phase[2:0];
    assign commit_o     = sel_i && fall && (phase == PH_LAST);
    assign commit_val_o = {val[BYTE_W-2:0], sdi_i};

    assert_phase_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= PH_DONE);
    assert_abort_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> (phase == '0 && cmd == '0 && val == '0));
    assert_edge_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && fall && phase != PH_DONE) |=> (phase == PHASE_W'($past(phase) + 1'b1)));
    assert_no_edge_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !fall) |=> $stable(phase));
endmodule

// File: rtl/nvr_regs.sv
// Module: nvr_regs
// RAM, status byte and interrupt with command decode for reads and commits.
// Assumes commit_i is a single-cycle pulse at frame end.
module nvr_regs
    import nvr_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] cmd_i,
    input  logic              commit_i,
    input  logic [BYTE_W-1:0] commit_val_i,
    input  logic              evt_set_i,
    output logic [BYTE_W-1:0] rd_byte_o,
    output logic              rd_type_o,
    output logic              irq_o
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [BYTE_W-1:0] DEPTH_B = BYTE_W'(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] status;
    logic              irq;
    logic              wr_hit;
    logic              ctl_clr;
    logic [AW-1:0]     idx;

    assign idx     = cmd_i[AW-1:0];
    assign wr_hit  = commit_i && (cmd_i >= RAM_WR_BASE) && (cmd_i < RAM_WR_BASE + DEPTH_B);
    assign ctl_clr = commit_i && (cmd_i == CMD_CTL) && commit_val_i[CLR_BIT];

    // Store committed bytes into the RAM; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_hit) begin
            mem[idx] <= commit_val_i;
        end
    end

    // Set or clear the pending-event bits and interrupt; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= STAT_RESET;
            irq    <= 1'b0;
        end else if (evt_set_i) begin
            status <= status | EVT_MASK;
            irq    <= 1'b1;
        end else if (ctl_clr) begin
            status <= status & ~EVT_MASK;
            irq    <= 1'b0;
        end
    end

    // Select the byte a read-type command returns.
    always_comb begin
        if (cmd_i < DEPTH_B)          rd_byte_o = mem[idx];
        else if (cmd_i == CMD_STAT)   rd_byte_o = status;
        else                          rd_byte_o = '0;
    end

    assign rd_type_o = (cmd_i < DEPTH_B) || (cmd_i == CMD_STAT) || (cmd_i == CMD_ZERO2)
                     || (cmd_i >= ZERO_LO && cmd_i <= ZERO_HI);
    assign irq_o = irq;

    assert_ram_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> mem[$past(idx)] == $past(commit_val_i));
    assert_irq_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status & EVT_MASK) == EVT_MASK);
    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_clr && !evt_set_i) |=> (!irq && (status & EVT_MASK) == '0));
    assert_other_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~EVT_MASK) == (STAT_RESET & ~EVT_MASK));
endmodule

// File: rtl/serial_nvram_slave.sv
// Module: serial_nvram_slave
// Top: synchronizes the three host lines, sequences frames, and serves the
// RAM, status and control commands. Assumes host lines change slowly
// compared with clk (several clocks per serial clock level).
module serial_nvram_slave
    import nvr_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_sel_i,
    input  logic host_sclk_i,
    input  logic host_sdata_i,
    input  logic evt_force_i,
    output logic slv_sdata_o,
    output logic slv_sdata_oe_o,
    output logic evt_irq_o
);
    logic [2:0]         sync_q;
    logic [PHASE_W-1:0] phase;
    logic [BYTE_W-1:0]  cmd;
    logic               window;
    logic [2:0]         bit_idx;
    logic               commit;
    logic [BYTE_W-1:0]  commit_val;
    logic [BYTE_W-1:0]  rd_byte;
    logic               rd_type;

    nvr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({host_sel_i, host_sclk_i, host_sdata_i}),
        .q_o   (sync_q)
    );

    nvr_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_i        (sync_q[2]),
        .sclk_i       (sync_q[1]),
        .sdi_i        (sync_q[0]),
        .phase_o      (phase),
        .cmd_o        (cmd),
        .window_o     (window),
        .bit_idx_o    (bit_idx),
        .commit_o     (commit),
        .commit_val_o (commit_val)
    );

    nvr_regs #(.DEPTH(DEPTH)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_i        (cmd),
        .commit_i     (commit),
        .commit_val_i (commit_val),
        .evt_set_i    (evt_force_i),
        .rd_byte_o    (rd_byte),
        .rd_type_o    (rd_type),
        .irq_o        (evt_irq_o)
    );

    assign slv_sdata_oe_o = window && rd_type;
    assign slv_sdata_o    = slv_sdata_oe_o && rd_byte[bit_idx];

    assert_oe_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slv_sdata_oe_o |-> (phase >= PHASE_W'(8) && phase <= PHASE_W'(15) && sync_q[2]));
    assert_data_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !slv_sdata_oe_o |-> !slv_sdata_o);
endmodule

// File: tb/serial_nvram_slave_test.sv
module serial_nvram_slave_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0, evt = 1'b0;
    logic sdo, oe, irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_mem [32];
    logic [7:0] m_stat;
    logic       m_irq;

    always #10 clk = ~clk;

    serial_nvram_slave uut (
        .clk(clk), .rst_n(rst_n), .host_sel_i(sel), .host_sclk_i(sclk),
        .host_sdata_i(sdi), .evt_force_i(evt), .slv_sdata_o(sdo),
        .slv_sdata_oe_o(oe), .evt_irq_o(irq)
    );

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_rd(input logic [7:0] c);
        return (c <= 8'h31);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] c);
        if (c < 8'h20) return m_mem[c[4:0]];
        if (c == 8'h30) return m_stat;
        return 8'h00;
    endfunction

    function automatic void model_commit(input logic [7:0] c, input logic [7:0] v);
        if (c >= 8'h80 && c <= 8'h9F) m_mem[c[4:0]] = v;
        if (c == 8'hB1 && v[2]) begin
            m_stat = m_stat & ~8'h18;
            m_irq  = 1'b0;
        end
    endfunction

    // Drive one frame; data is inverted while clock is high to expose rising-edge sampling (R2).
    task automatic frame(input logic [7:0] c, input logic [7:0] v, input int nbits,
                         input int extra, output logic [7:0] rd, output int oe_bad);
        oe_bad = 0;
        rd = 8'h00;
        sel = 1'b1;
        tick(6);
        if (oe !== 1'b0) oe_bad++;
        for (int i = 0; i < nbits; i++) begin
            logic b;
            b = (i < 8) ? c[7-i] : v[15-i];
            sdi = ~b; sclk = 1'b1; tick(3);
            sdi = b;  tick(3);
            sclk = 1'b0; tick(6);
            begin
                int ph;
                bit eo;
                ph = i + 1;
                eo = (ph >= 8 && ph <= 15) && is_rd(c);
                if (oe !== eo) oe_bad++;
                if (eo) rd[15-ph] = sdo;
            end
        end
        for (int k = 0; k < extra; k++) begin
            sdi = 1'b1; sclk = 1'b1; tick(6);
            sclk = 1'b0; tick(6);
            if (oe !== 1'b0) oe_bad++;
        end
        sel = 1'b0; sdi = 1'b0;
        tick(6);
        if (nbits == 16) model_commit(c, v);
    endtask

    task automatic pulse_evt();
        evt = 1'b1; tick(1);
        evt = 1'b0; tick(2);
        m_stat = m_stat | 8'h18;
        m_irq  = 1'b1;
    endtask

    initial begin
        logic [7:0] rd;
        int ob;
        void'($urandom(32'h5EED_0101));
        for (int i = 0; i < 32; i++) m_mem[i] = 8'h00;
        m_stat = 8'h90;
        m_irq  = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R1: reset state
        chk("R1 irq", irq, 0);
        chk("R1 oe", oe, 0);
        frame(8'h30, 8'h00, 16, 0, rd, ob);
        chk("R1 R5 status reset", rd, 8'h90);
        chk("R7 oe status frame", ob, 0);
        frame(8'h05, 8'h00, 16, 0, rd, ob);
        chk("R1 ram reset", rd, 8'h00);

        // R4 R3 R2: write then read back
        frame(8'h85, 8'hA5, 16, 0, rd, ob);
        chk("R7 oe write frame", ob, 0);
        frame(8'h05, 8'h00, 16, 0, rd, ob);
        chk("R3 R4 readback 05", rd, 8'hA5);
        frame(8'h9F, 8'h3C, 16, 0, rd, ob);
        frame(8'h1F, 8'h00, 16, 0, rd, ob);
        chk("R4 top address", rd, 8'h3C);

        // R8: aborted write
        frame(8'h85, 8'h00, 12, 0, rd, ob);
        frame(8'h05, 8'h00, 16, 0, rd, ob);
        chk("R8 abort keeps ram", rd, 8'hA5);

        // R9: extra edges after the frame
        frame(8'h80, 8'h77, 16, 3, rd, ob);
        chk("R9 extra edges oe", ob, 0);
        frame(8'h00, 8'h00, 16, 2, rd, ob);
        chk("R9 new frame phase 0", rd, 8'h77);
        chk("R9 R7 oe after done", ob, 0);

        // R6: zero-returning commands with enable
        frame(8'h31, 8'h00, 16, 0, rd, ob);
        chk("R6 cmd 31 data", rd, 8'h00);
        chk("R6 cmd 31 oe", ob, 0);
        frame(8'h2A, 8'h00, 16, 0, rd, ob);
        chk("R6 cmd 2A data", rd, 8'h00);

        // R10: event set
        pulse_evt();
        chk("R10 irq set", irq, 1);
        frame(8'h30, 8'h00, 16, 0, rd, ob);
        chk("R10 status set", rd, 8'h98);

        // R11: clear with bit 2 clear has no effect, then with bit 2 set
        frame(8'hB1, 8'hFB, 16, 0, rd, ob);
        chk("R11 no clear irq", irq, 1);
        frame(8'hB1, 8'h04, 12, 0, rd, ob);
        chk("R8 R11 aborted clear", irq, 1);
        frame(8'hB1, 8'h04, 16, 0, rd, ob);
        chk("R11 clear irq", irq, 0);
        frame(8'h30, 8'h00, 16, 0, rd, ob);
        chk("R12 status after clear", rd, 8'h80);

        // Random mix against the bench model
        for (int t = 0; t < 60; t++) begin
            logic [7:0] c, v;
            int cls;
            cls = $urandom % 6;
            v = 8'($urandom);
            case (cls)
                0: c = 8'($urandom % 32);
                1: c = 8'h80 + 8'($urandom % 32);
                2: c = 8'h30;
                3: c = ($urandom % 2) ? 8'h31 : 8'h20 + 8'($urandom % 16);
                4: c = 8'h40 + 8'($urandom % 64);
                default: begin
                    c = 8'hB1;
                    if ($urandom % 2) pulse_evt();
                end
            endcase
            frame(c, v, 16, 0, rd, ob);
            chk("R7 random oe", ob, 0);
            if (is_rd(c)) chk("R3 R5 R6 random read", rd, exp_rd(c));
            chk("R11 random irq", irq, m_irq);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule